// File: doc/BRIEF.md
# Pulse Charge Integrator with Floating End

This block sums the baseline-corrected samples of one ADC channel over each detected pulse. Every clock it takes one 12-bit sample and the channel's current baseline. It forms a signed corrected value, inverting by default so that negative-going pulses read as positive. An integration interval opens on an externally supplied arrival strobe. It closes at the first of three events: the signal has decayed to 1/32 of its tracked peak, a programmable sample count has been reached, or a second pulse has risen out of an inter-pulse minimum.

On a pile-up the block closes the running interval retroactively at the minimum. It then opens a new interval for the following peak. The new interval holds the samples taken after the minimum and is still measured against the common baseline. Each closed interval gives at most one result: a saturated 20-bit signed charge, an overflow flag, a pile-up flag and the index of the interval within the pulse chain. A per-channel charge threshold suppresses small results.

Top module: `pulse_charge_integrator`

## Requirements
- R1: The corrected value is baseline minus sample when `positive_i` is 0, and sample minus baseline when `positive_i` is 1.
- R2: While idle, `start_i` opens an interval that includes the sample presented with the strobe. A `start_i` during an open interval has no effect.
- R3: An interval closes on the sample whose corrected value is at most the tracked peak arithmetically shifted right by 5, and that sample is included. The tracked peak is the largest corrected value of the interval, including the current sample.
- R4: An interval closes on the sample that brings its sample count to `max_len_i`. A value of 0 selects 1023.
- R5: A pile-up is detected on a sample when three conditions all hold: at least three samples have followed the current minimum, the sum of the current and three previous corrected values exceeds four times the minimum by more than 4·L, and the interval was not just closed. L is `detect_lvl_i`, or 8 when that field is 0.
- R6: A pile-up is only accepted once at least `rearm_i` clocks have passed since the last rise of the tracked peak. The count saturates at 15.
- R7: On a pile-up, the result is the sum up to and including the minimum, with `q_pileup_o`=1. A new interval then starts, holding the samples after the minimum plus the current one. Its peak and minimum are both the current sample, and its index is one higher, saturating at 7. The first interval after a start has index 0.
- R8: When several close conditions meet on one sample, the length limit wins over decay, and decay wins over pile-up. A close by length or decay includes the current sample and reports `q_pileup_o`=0.
- R9: A result is presented only when `charge_thr_i` is 0 or the signed sum is at least `charge_thr_i`. Hence a negative result requires a zero threshold.
- R10: A sum above 524287 or below -524288 is reported as that limit with `q_ovf_o`=1. Otherwise `q_ovf_o` is 0.
- R11: Each result appears as a single-cycle `q_vld_o`, in the clock after the sample that closed the interval. After reset `q_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 12 | Raw ADC sample |
| baseline_i | input | 12 | Current channel baseline |
| positive_i | input | 1 | 1 analyses positive pulses (no inversion) |
| start_i | input | 1 | Pulse arrival strobe |
| charge_thr_i | input | 12 | Minimum charge for a result, 0 passes all |
| detect_lvl_i | input | 4 | Pile-up detection level factor, 0 means 8 |
| rearm_i | input | 4 | Clocks after last peak rise before pile-up may fire |
| max_len_i | input | 10 | Maximum samples per interval, 0 means 1023 |
| q_vld_o | output | 1 | Result strobe |
| q_o | output | 20 | Signed saturated charge |
| q_pileup_o | output | 1 | Interval was closed by a pile-up |
| q_index_o | output | 3 | Interval index within the pulse chain |
| q_ovf_o | output | 1 | Charge was saturated |

## Verification
The properties assume that the configuration inputs hold still across the edge at which a result is produced. The threshold property also relies on the threshold seen at the closing sample being the one in force when the result is checked. The bench changes configuration only between pulse episodes, while the channel has been flushed with baseline-level samples. The random stimulus builds shaped pulses, sometimes overlapping, on a random baseline with small noise. Samples are clamped to the 12-bit range, so the corrected value never leaves the 13-bit signed span the datapath is sized for.

// File: rtl/pulse_charge_integrator.sv
module pulse_charge_integrator #(
  parameter int SW = 12,
  parameter int QW = 20,
  parameter int LW = 10,
  parameter int IW = 3,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sample_i,
  input  logic [SW-1:0] baseline_i,
  input  logic          positive_i,
  input  logic          start_i,
  input  logic [SW-1:0] charge_thr_i,
  input  logic [3:0]    detect_lvl_i,
  input  logic [HW-1:0] rearm_i,
  input  logic [LW-1:0] max_len_i,
  output logic          q_vld_o,
  output logic [QW-1:0] q_o,
  output logic          q_pileup_o,
  output logic [IW-1:0] q_index_o,
  output logic          q_ovf_o
);
  localparam int CW = SW + 1;
  localparam int AW = SW + LW + 1;
  localparam int MW = CW + 4;
  localparam logic signed [AW-1:0] QMAX = AW'((1 << (QW - 1)) - 1);
  localparam logic signed [AW-1:0] QMIN = ~QMAX;

  logic                 busy;
  logic signed [AW-1:0] acc, tail;
  logic [LW-1:0]        len, tlen;
  logic signed [CW-1:0] peak, valley;
  logic signed [CW-1:0] d1, d2, d3;
  logic [HW-1:0]        hold;
  logic [IW-1:0]        idx;

  logic signed [CW-1:0] c;
  assign c = positive_i ? $signed({1'b0, sample_i}) - $signed({1'b0, baseline_i})
                        : $signed({1'b0, baseline_i}) - $signed({1'b0, sample_i});

  logic signed [CW+1:0] sum4;
  logic signed [MW-1:0] metric, level;
  logic [3:0]           lvl_eff;
  assign sum4    = (CW+2)'(c) + (CW+2)'(d1) + (CW+2)'(d2) + (CW+2)'(d3);
  assign metric  = MW'(sum4) - (MW'(valley) <<< 2);
  assign lvl_eff = (detect_lvl_i == 4'd0) ? 4'd8 : detect_lvl_i;
  assign level   = MW'({lvl_eff, 2'b00});

  logic                 act, newpk, decay, lenhit, pile, fin, split, emit, pass, ovf;
  logic signed [AW-1:0] acc_b, acc1, emit_val, thr_s;
  logic [LW-1:0]        len_b, len1, maxl;
  logic signed [CW-1:0] peak1;

  assign act    = busy | start_i;
  assign acc_b  = busy ? acc : '0;
  assign len_b  = busy ? len : '0;
  assign newpk  = !busy || (c > peak);
  assign acc1   = acc_b + AW'(c);
  assign len1   = len_b + LW'(1);
  assign peak1  = newpk ? c : peak;
  assign maxl   = (max_len_i == '0) ? '1 : max_len_i;
  assign decay  = c <= (peak1 >>> 5);
  assign lenhit = len1 >= maxl;
  assign pile   = busy && (tlen >= LW'(3)) && (hold >= rearm_i) && (metric > level);
  assign fin    = act && (lenhit || decay);
  assign split  = act && !fin && pile;
  assign emit   = fin || split;

  assign emit_val = split ? acc - tail : acc1;
  assign thr_s    = AW'({1'b0, charge_thr_i});
  assign pass     = (charge_thr_i == '0) || (emit_val >= thr_s);
  assign ovf      = (emit_val > QMAX) || (emit_val < QMIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1 <= '0;
      d2 <= '0;
      d3 <= '0;
    end else begin
      d1 <= c;
      d2 <= d1;
      d3 <= d2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      acc    <= '0;
      len    <= '0;
      tail   <= '0;
      tlen   <= '0;
      peak   <= '0;
      valley <= '0;
      hold   <= '0;
      idx    <= '0;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (split) begin
      acc    <= tail + AW'(c);
      len    <= tlen + LW'(1);
      peak   <= c;
      valley <= c;
      tail   <= '0;
      tlen   <= '0;
      hold   <= '0;
      idx    <= (idx == '1) ? idx : idx + IW'(1);
    end else if (act) begin
      busy <= 1'b1;
      acc  <= acc1;
      len  <= len1;
      peak <= peak1;
      if (!busy) idx <= '0;
      if (newpk) begin
        valley <= c;
        tail   <= '0;
        tlen   <= '0;
        hold   <= '0;
      end else begin
        hold <= (hold == '1) ? hold : hold + HW'(1);
        if (c < valley) begin
          valley <= c;
          tail   <= '0;
          tlen   <= '0;
        end else begin
          tail <= tail + AW'(c);
          tlen <= tlen + LW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld_o    <= 1'b0;
      q_o        <= '0;
      q_pileup_o <= 1'b0;
      q_index_o  <= '0;
      q_ovf_o    <= 1'b0;
    end else begin
      q_vld_o <= emit && pass;
      if (emit) begin
        q_o        <= ovf ? ((emit_val > QMAX) ? QMAX[QW-1:0] : QMIN[QW-1:0]) : emit_val[QW-1:0];
        q_pileup_o <= split;
        q_index_o  <= busy ? idx : '0;
        q_ovf_o    <= ovf;
      end
    end
  end
endmodule

// File: rtl/pulse_charge_integrator_checks.sv
module pulse_charge_integrator_checks #(
  parameter int SW = 12,
  parameter int QW = 20,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy,
  input logic [SW-1:0] charge_thr_i,
  input logic          q_vld_o,
  input logic [QW-1:0] q_o,
  input logic          q_ovf_o,
  input logic [IW-1:0] q_index_o
);
  localparam logic [QW-1:0] QPOS = {1'b0, {(QW-1){1'b1}}};
  localparam logic [QW-1:0] QNEG = {1'b1, {(QW-1){1'b0}}};

  p_sat_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld_o && q_ovf_o) |-> (q_o == QPOS || q_o == QNEG));

  p_thr_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld_o && $past(charge_thr_i) != '0) |-> !q_o[QW-1]);

  p_needs_activity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld_o |-> $past(busy || start_i));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> !q_vld_o);

  p_first_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld_o && $past(!busy)) |-> (q_index_o == '0));
endmodule

bind pulse_charge_integrator pulse_charge_integrator_checks #(.SW(SW), .QW(QW), .IW(IW)) u_checks (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy),
  .charge_thr_i(charge_thr_i), .q_vld_o(q_vld_o), .q_o(q_o),
  .q_ovf_o(q_ovf_o), .q_index_o(q_index_o)
);

// File: tb/test_pulse_charge_integrator.sv
module test_pulse_charge_integrator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] sample = 12'd0, baseline = 12'd0, thr = 12'd0;
  logic positive = 1'b0, start = 1'b0;
  logic [3:0] lvl = 4'd0, rearm = 4'd1;
  logic [9:0] maxlen = 10'd0;
  logic q_vld, q_pile, q_ovf;
  logic [19:0] q;
  logic [2:0] q_idx;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_charge_integrator i_pulse_charge_integrator (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .baseline_i(baseline),
    .positive_i(positive), .start_i(start), .charge_thr_i(thr),
    .detect_lvl_i(lvl), .rearm_i(rearm), .max_len_i(maxlen),
    .q_vld_o(q_vld), .q_o(q), .q_pileup_o(q_pile), .q_index_o(q_idx), .q_ovf_o(q_ovf)
  );

  // reference state
  bit m_busy;
  longint m_acc, m_tail;
  int m_len, m_tlen, m_peak, m_valley, m_hold, m_idx, md1, md2, md3;

  function automatic longint sat(longint v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return v;
  endfunction

  task automatic model_reset();
    m_busy = 0; m_acc = 0; m_tail = 0; m_len = 0; m_tlen = 0;
    m_peak = 0; m_valley = 0; m_hold = 0; m_idx = 0; md1 = 0; md2 = 0; md3 = 0;
  endtask

  task automatic model_step(output bit ev, output longint val, output bit epile, output int eidx);
    int c, s4, lv, ml, len1, peak1;
    bit act, newpk, decay, lenhit, pile, fin, split;
    longint acc1;
    c = positive ? int'(sample) - int'(baseline) : int'(baseline) - int'(sample);
    s4 = c + md1 + md2 + md3;
    lv = ((lvl == 0) ? 8 : int'(lvl)) * 4;
    ml = (maxlen == 0) ? 1023 : int'(maxlen);
    act = m_busy || start;
    newpk = !m_busy || c > m_peak;
    acc1 = (m_busy ? m_acc : 0) + c;
    len1 = (m_busy ? m_len : 0) + 1;
    peak1 = newpk ? c : m_peak;
    decay = c <= (peak1 >>> 5);
    lenhit = len1 >= ml;
    pile = m_busy && m_tlen >= 3 && m_hold >= int'(rearm) && (s4 - 4*m_valley) > lv;
    fin = act && (lenhit || decay);
    split = act && !fin && pile;
    val = split ? m_acc - m_tail : acc1;
    eidx = m_busy ? m_idx : 0;
    epile = split;
    ev = (fin || split) && (thr == 0 || val >= longint'(thr));
    if (fin) m_busy = 0;
    else if (split) begin
      m_acc = m_tail + c; m_len = m_tlen + 1; m_peak = c; m_valley = c;
      m_tail = 0; m_tlen = 0; m_hold = 0; m_idx = (m_idx == 7) ? 7 : m_idx + 1;
    end else if (act) begin
      if (!m_busy) m_idx = 0;
      m_busy = 1; m_acc = acc1; m_len = len1; m_peak = peak1;
      if (newpk) begin m_valley = c; m_tail = 0; m_tlen = 0; m_hold = 0; end
      else begin
        m_hold = (m_hold == 15) ? 15 : m_hold + 1;
        if (c < m_valley) begin m_valley = c; m_tail = 0; m_tlen = 0; end
        else begin m_tail = m_tail + c; m_tlen = m_tlen + 1; end
      end
    end
    md3 = md2; md2 = md1; md1 = c;
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one sample: drive, clock, step the model, compare outputs
  task automatic tick(int s, bit st);
    bit ev, ep; longint val; int ei; string tag;
    sample = 12'(s); start = st;
    @(posedge clk);
    model_step(ev, val, ep, ei);
    #2;
    tag = ep ? "R7" : ((val > 524287 || val < -524288) ? "R10" : "R3");
    if (!ev) chk("R9 valid", longint'(q_vld), 0);
    else begin
      checks++;
      if (!q_vld || longint'($signed(q)) != sat(val) || q_pile != ep ||
          int'(q_idx) != ei || q_ovf != (sat(val) != val)) begin
        fails++;
        $display("FAIL %s vld=%0b q=%0d pile=%0b idx=%0d ovf=%0b expected q=%0d pile=%0b idx=%0d",
                 tag, q_vld, $signed(q), q_pile, q_idx, q_ovf, sat(val), ep, ei);
      end
    end
  endtask

  task automatic defaults();
    positive = 0; thr = 0; lvl = 0; rearm = 1; maxlen = 0;
  endtask

  task automatic flush();
    for (int k = 0; k < 6; k++) tick(int'(baseline), 0);
  endtask

  task automatic seq_neg(int base, int cs[], int n);
    baseline = 12'(base);
    for (int k = 0; k < n; k++) tick(base - cs[k], k == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int pl[11];
    int a, r, tau, v, v2, off, n;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    chk("R11 reset vld", longint'(q_vld), 0);
    chk("R11 reset q", longint'(q), 0);
    rst_n = 1;

    // R1 R3 negative polarity, decay end, R4 max_len 0 means 1023
    defaults(); baseline = 100; flush();
    tick(90, 1); tick(60, 0); tick(80, 0);
    chk("R3 not yet closed", longint'(q_vld), 0);
    tick(99, 0);
    chk("R3 decay close vld", longint'(q_vld), 1);
    chk("R1 R3 decay sum", longint'($signed(q)), 71);
    // R1 positive polarity
    positive = 1; flush();
    tick(110, 1); tick(140, 0); tick(120, 0); tick(101, 0);
    chk("R1 positive sum", longint'($signed(q)), 71);
    positive = 0; flush();

    // R5 R7 pile-up split
    pl = '{10,100,60,30,20,25,40,70,90,50,2};
    baseline = 1000; flush();
    for (int k = 0; k < 8; k++) tick(1000 - pl[k], k == 0);
    chk("R5 no early pile-up", longint'(q_vld), 0);
    tick(1000 - pl[8], 0);
    chk("R7 pile vld", longint'(q_vld), 1);
    chk("R7 pile sum to minimum", longint'($signed(q)), 220);
    chk("R7 pile flag", longint'(q_pile), 1);
    chk("R7 pile index", longint'(q_idx), 0);
    tick(1000 - pl[9], 0); tick(1000 - pl[10], 0);
    chk("R7 second sum", longint'($signed(q)), 277);
    chk("R7 second index", longint'(q_idx), 1);
    chk("R7 second flag", longint'(q_pile), 0);
    flush();

    // R6 rearm distance blocks pile-up
    rearm = 15;
    for (int k = 0; k < 9; k++) tick(1000 - pl[k], k == 0);
    chk("R6 held off", longint'(q_vld), 0);
    tick(998, 0);
    chk("R6 merged sum", longint'($signed(q)), 447);
    rearm = 1; flush();

    // R8 length beats pile-up
    maxlen = 9;
    for (int k = 0; k < 9; k++) tick(1000 - pl[k], k == 0);
    chk("R8 length close sum", longint'($signed(q)), 445);
    chk("R8 no pile flag", longint'(q_pile), 0);
    maxlen = 0; flush();

    // R5 detection level
    pl = '{10,100,60,30,20,25,30,35,45,0,0};
    for (int k = 0; k < 9; k++) tick(1000 - pl[k], k == 0);
    chk("R5 default level pile", longint'(q_pile & q_vld), 1);
    chk("R5 default level sum", longint'($signed(q)), 220);
    flush();
    lvl = 15;
    for (int k = 0; k < 9; k++) tick(1000 - pl[k], k == 0);
    chk("R5 high level no pile", longint'(q_vld), 0);
    lvl = 0; flush();

    // R4 length limit, R2 start while busy ignored
    maxlen = 5; baseline = 500;
    tick(450, 1); tick(450, 0); tick(450, 1); tick(450, 0);
    chk("R4 before limit", longint'(q_vld), 0);
    tick(450, 0);
    chk("R2 R4 length sum", longint'($signed(q)), 250);
    tick(500, 0);
    chk("R11 single cycle", longint'(q_vld), 0);
    maxlen = 0; flush();

    // R10 saturation
    positive = 1; baseline = 0; maxlen = 200;
    for (int k = 0; k < 200; k++) tick(4095, k == 0);
    chk("R10 saturated value", longint'($signed(q)), 524287);
    chk("R10 overflow flag", longint'(q_ovf), 1);
    defaults(); baseline = 100; flush();

    // R9 threshold
    tick(105, 1);
    chk("R9 negative with zero threshold", longint'($signed(q)), -5);
    thr = 10; flush();
    tick(105, 1);
    chk("R9 negative suppressed", longint'(q_vld), 0);
    maxlen = 1; flush();
    tick(92, 1);
    chk("R9 below threshold", longint'(q_vld), 0);
    tick(88, 1);
    chk("R9 above threshold", longint'($signed(q)), 12);
    defaults(); flush();

    // random shaped pulses, occasional overlaps and stray strobes
    for (int ep = 0; ep < 260; ep++) begin
      positive = 1'($urandom_range(0, 1));
      baseline = 12'($urandom_range(600, 3400));
      lvl = 4'($urandom_range(0, 15));
      rearm = 4'($urandom_range(0, 5));
      case ($urandom_range(0, 3))
        0: maxlen = 0;
        1: maxlen = 10'($urandom_range(1, 1023));
        default: maxlen = 10'($urandom_range(8, 60));
      endcase
      thr = ($urandom_range(0, 2) == 0) ? 12'($urandom_range(1, 3000)) : 12'd0;
      flush();
      a = $urandom_range(40, 550); r = $urandom_range(2, 6); tau = $urandom_range(3, 12);
      off = $urandom_range(8, 30); n = $urandom_range(50, 75);
      v = 0; v2 = 0;
      for (int k = 0; k < n; k++) begin
        int s, p;
        p = (k < 4) ? 0 : ((k - 4 < r) ? a * (k - 3) / r : v - v / tau);
        v = p;
        if (k >= 4 + off && (ep % 3 == 0)) v2 = (k - 4 - off < r) ? (a/2) * (k - 3 - off) / r : v2 - v2 / tau;
        p = v + v2 + int'($urandom_range(0, 4)) - 2;
        s = positive ? int'(baseline) + p : int'(baseline) - p;
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        tick(s, (k == 4) || ($urandom_range(0, 49) == 0));
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule